// File: doc/BRIEF.md
# Multi-Mode Timer/Event Counter

This block is an up-counter with two compare registers, an event strobe input, a single toggling or pulse-width-modulated output, a one-cycle interrupt pulse and an 8-bit control register. A small register bus reaches the control register, the compare registers and the live count. The counter width defaults to 16 bits. The event strobe arrives already qualified: polarity selection and input sampling happen outside the block, so a strobe high for one clock is one valid edge. The counter advances once per clock whenever the block is running.

A 3-bit mode field controls four things: whether the timer runs, what clears the count (nothing, an event edge, or a match with compare register 0), whether the output is PWM or toggles, and whether event edges also toggle the output. A sticky overflow flag records each time the count advances from all ones to zero. Software configures the compare values while the timer is stopped and then writes a mode. Once the timer is running, the only mode change it accepts is a return to stop.

Top module: `mm_timer`

## Requirements
- R1: After synchronous reset, tout, irq, rdata, the count and the control register are all 0. The register addresses are 0 = control, 1 = compare 0, 2 = compare 1, 3 = count (read only). rdata shows the register selected by addr in the previous cycle. Control bit 0 is the overflow flag, bits 3:1 are the mode, and all higher bits read 0.
- R2: Mode 000 stops the timer. The count is held at 0, irq stays low and tout keeps its value.
- R3: Mode 001 is PWM on a free-running count. tout goes to 1 in the cycle after the count is all ones (the wrap) and goes to 0 in the cycle after a compare-0 match. If both happen in the same cycle, the wrap wins.
- R4: In PWM mode, a write to compare 0 goes to a buffer, and the active compare-0 value loads from that buffer only at a wrap. In the other modes the active value follows the buffer one cycle after a write.
- R5: Modes 010 and 011 count freely. The count rises by 1 each clock and wraps from all ones to 0.
- R6: Modes 100 and 101 load 0 into the count on the clock after a cycle in which the event strobe is high.
- R7: Modes 110 and 111 load 0 into the count on the clock after the count equals compare 0. The count therefore runs 0 to compare 0 inclusive.
- R8: In modes 010 to 111, tout inverts once on the clock after a match with compare 0, with compare 1, or with both at the same time.
- R9: In modes 011, 101 and 111, a cycle with the event strobe high also inverts tout. Any number of toggle causes in one cycle gives a single inversion.
- R10: In every mode except 000, irq is high for the cycle after each cycle in which the count equals compare 0 or compare 1.
- R11: The overflow flag is set on the clock after a running count sits at all ones. This includes mode 110/111 with compare 0 set to all ones.
- R12: A control write with bit 0 = 0 clears the overflow flag. A control write with bit 0 = 1 leaves the flag unchanged. An overflow in the same cycle as a clearing write sets the flag.
- R13: A control write that would move the mode from one non-zero code to a different non-zero code leaves the mode unchanged. Writes to 000, and any write made while the mode is 000, take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wdata | input | W | Write data |
| rdata | output | W | Registered read data |
| evt_edge | input | 1 | Pre-qualified event edge strobe |
| tout | output | 1 | Timer output |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The overflow flag has two hard-to-reach cases: a wrap caused by a compare-0 clear at all ones, and the PWM compare buffer loading exactly at the wrap. Both need the count to reach its top value. The bench therefore builds the design with an 8-bit counter, so every wrap is only a few hundred cycles away. The bench keeps a cycle-level expectation of tout, irq and rdata for every clock. It changes compare 0 partway through a PWM period, strobes events while both compare registers hold the same value, and tries locked mode changes. Each of these is checked both by the per-cycle expectation and by direct register reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MD_STOP   = 3'b000,
    MD_PWM    = 3'b001,
    MD_FREE0  = 3'b010,
    MD_FREE1  = 3'b011,
    MD_EDGE0  = 3'b100,
    MD_EDGE1  = 3'b101,
    MD_MATCH0 = 3'b110,
    MD_MATCH1 = 3'b111
  } tmr_mode_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMP0 = 2'd1;
  localparam logic [1:0] A_CMP1 = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;
  localparam int NUM_CMP = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         wrap,
  input  logic [W-1:0] count,
  output tmr_mode_e    mode,
  output logic         ovf,
  output logic [W-1:0] cmp0_act,
  output logic [W-1:0] cmp1,
  output logic [W-1:0] rdata
);
  localparam int PAD = W - 4;

  logic [W-1:0] cmp0_buf;
  logic         ctrl_wr;
  tmr_mode_e    req_mode;
  logic         mode_ok;

  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign req_mode = tmr_mode_e'(wdata[3:1]);
  // a running timer only accepts a return to stop
  assign mode_ok  = (mode == MD_STOP) || (req_mode == MD_STOP) || (req_mode == mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MD_STOP;
      ovf      <= 1'b0;
      cmp0_buf <= '0;
      cmp0_act <= '0;
      cmp1     <= '0;
      rdata    <= '0;
    end else begin
      if (ctrl_wr && mode_ok) mode <= req_mode;
      if (wrap) ovf <= 1'b1;
      else if (ctrl_wr && !wdata[0]) ovf <= 1'b0;
      if (wr_en && addr == A_CMP0) cmp0_buf <= wdata;
      if (wr_en && addr == A_CMP1) cmp1 <= wdata;
      if (mode != MD_PWM || wrap) cmp0_act <= cmp0_buf;
      case (addr)
        A_CTRL:  rdata <= {{PAD{1'b0}}, mode, ovf};
        A_CMP0:  rdata <= cmp0_buf;
        A_CMP1:  rdata <= cmp1;
        default: rdata <= count;
      endcase
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  tmr_mode_e          mode,
  input  logic [W-1:0]       cmp0_act,
  input  logic [W-1:0]       cmp1,
  input  logic               evt_edge,
  output logic [W-1:0]       count,
  output logic [NUM_CMP-1:0] match,
  output logic               wrap
);
  logic [W-1:0] cmp_val [NUM_CMP];
  logic         run;
  logic         clr;

  assign cmp_val[0] = cmp0_act;
  assign cmp_val[1] = cmp1;
  assign run        = (mode != MD_STOP);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_match
    assign match[i] = run && (count == cmp_val[i]);
  end

  assign wrap = run && (&count);
  assign clr  = ((mode == MD_EDGE0 || mode == MD_EDGE1) && evt_edge) ||
                ((mode == MD_MATCH0 || mode == MD_MATCH1) && match[0]);

  always_ff @(posedge clk) begin
    if (rst || !run || clr) count <= '0;
    else                    count <= count + 1'b1;
  end
endmodule

// File: rtl/tmr_outctl.sv
module tmr_outctl
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  tmr_mode_e          mode,
  input  logic [NUM_CMP-1:0] match,
  input  logic               wrap,
  input  logic               evt_edge,
  output logic               tout,
  output logic               irq
);
  logic [2:0] mbits;
  logic       run;
  logic       toggle;

  assign mbits  = mode;
  assign run    = (mode != MD_STOP);
  assign toggle = (|match) || (mbits[0] && evt_edge);

  always_ff @(posedge clk) begin
    if (rst) begin
      tout <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= |match;
      if (mode == MD_PWM) begin
        if (wrap)          tout <= 1'b1;
        else if (match[0]) tout <= 1'b0;
      end else if (run && toggle) begin
        tout <= ~tout;
      end
    end
  end
endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         evt_edge,
  output logic         tout,
  output logic         irq
);
  tmr_mode_e          mode_q;
  logic               ovf_q;
  logic [W-1:0]       cmp0_act;
  logic [W-1:0]       cmp1_q;
  logic [W-1:0]       count_q;
  logic [NUM_CMP-1:0] match;
  logic               wrap;

  tmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wrap(wrap), .count(count_q), .mode(mode_q), .ovf(ovf_q),
    .cmp0_act(cmp0_act), .cmp1(cmp1_q), .rdata(rdata)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .mode(mode_q), .cmp0_act(cmp0_act), .cmp1(cmp1_q),
    .evt_edge(evt_edge), .count(count_q), .match(match), .wrap(wrap)
  );

  tmr_outctl u_out (
    .clk(clk), .rst(rst), .mode(mode_q), .match(match), .wrap(wrap),
    .evt_edge(evt_edge), .tout(tout), .irq(irq)
  );
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [2:0]   mode,
  input logic         ovf,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp0_act,
  input logic [W-1:0] cmp1,
  input logic         tout,
  input logic         irq
);
  a_r2_stop_count_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b000) |=> (count == '0));
  a_r2_stop_no_irq: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b000) |=> !irq);
  a_r3_pwm_high_after_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b001 && (&count)) |=> tout);
  a_r10_irq_after_match: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'b000 && (count == cmp0_act || count == cmp1)) |=> irq);
  a_r11_ovf_after_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'b000 && (&count)) |=> ovf);
  a_r13_mode_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0 && mode != 3'b000 && wdata[3:1] != 3'b000 &&
     wdata[3:1] != mode) |=> $stable(mode));
endmodule

bind mm_timer mm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mode(mode_q), .ovf(ovf_q), .count(count_q), .cmp0_act(cmp0_act),
  .cmp1(cmp1_q), .tout(tout), .irq(irq)
);

// File: tb/mm_timer_bench.sv
module mm_timer_bench;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd3;
  logic [W-1:0] wdata = '0;
  logic         evt_edge = 1'b0;
  logic [W-1:0] rdata;
  logic         tout, irq;

  int vec = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  mm_timer #(.W(W)) u_mm_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_edge(evt_edge), .tout(tout), .irq(irq)
  );

  typedef struct {
    logic         t;
    logic         i;
    logic [W-1:0] r;
    string        tg;
  } exp_t;
  exp_t sbq[$];

  // expectation built from the requirement text
  logic [2:0]   m_mode;
  logic         m_ovf, m_tout, m_irq;
  logic [W-1:0] m_c0b, m_c0, m_c1, m_cnt, m_rd;

  always @(posedge clk) begin
    logic run, m0, m1, wr;
    logic [2:0] nm;
    logic [W-1:0] ncnt;
    exp_t e;
    if (rst) begin
      m_mode = 0; m_ovf = 0; m_tout = 0; m_irq = 0;
      m_c0b = 0; m_c0 = 0; m_c1 = 0; m_cnt = 0; m_rd = 0;
    end else begin
      run = (m_mode != 3'b000);
      m0 = run && (m_cnt == m_c0);
      m1 = run && (m_cnt == m_c1);
      wr = run && (m_cnt == ONES);
      case (addr)
        2'd0: m_rd = {{(W-4){1'b0}}, m_mode, m_ovf};
        2'd1: m_rd = m_c0b;
        2'd2: m_rd = m_c1;
        default: m_rd = m_cnt;
      endcase
      if (!run) ncnt = 0;
      else if (m_mode[2:1] == 2'b10 && evt_edge) ncnt = 0;     // R6
      else if (m_mode[2:1] == 2'b11 && m0) ncnt = 0;           // R7
      else ncnt = m_cnt + 1'b1;                                // R5
      m_irq = m0 || m1;                                        // R10
      if (m_mode == 3'b001) begin                              // R3
        if (wr) m_tout = 1;
        else if (m0) m_tout = 0;
      end else if (run && (m0 || m1 || (m_mode[0] && evt_edge)))
        m_tout = ~m_tout;                                      // R8 R9
      if (m_mode != 3'b001 || wr) m_c0 = m_c0b;                // R4
      if (wr) m_ovf = 1;                                       // R11
      else if (wr_en && addr == 2'd0 && !wdata[0]) m_ovf = 0;  // R12
      if (wr_en && addr == 2'd0) begin                         // R13
        nm = wdata[3:1];
        if (m_mode == 0 || nm == 0 || nm == m_mode) m_mode = nm;
      end
      if (wr_en && addr == 2'd1) m_c0b = wdata;
      if (wr_en && addr == 2'd2) m_c1 = wdata;
      m_cnt = ncnt;
    end
    e.t = m_tout; e.i = m_irq; e.r = m_rd; e.tg = tag;
    sbq.push_back(e);
  end

  always @(negedge clk) begin
    exp_t e;
    if (!done && sbq.size() > 0) begin
      e = sbq.pop_front();
      vec++;
      if (tout !== e.t || irq !== e.i || rdata !== e.r) begin
        bad++;
        $display("FAIL %s: tout/irq/rdata got %0b/%0b/%0h expected %0b/%0b/%0h",
                 e.tg, tout, irq, rdata, e.t, e.i, e.r);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = 2'd3;
  endtask

  task automatic pulse;
    @(negedge clk);
    evt_edge = 1;
    @(negedge clk);
    evt_edge = 0;
  endtask

  task automatic check_rd(input logic [1:0] a, input logic [W-1:0] x, input string rq);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    vec++;
    if (rdata !== x) begin
      bad++;
      $display("FAIL %s: read addr %0d got %0h expected %0h", rq, a, rdata, x);
    end
    addr = 2'd3;
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 0;
    tag = "R1"; check_rd(2'd0, 8'h00, "R1");
    tag = "R2"; wr(2'd1, 8'd5); wr(2'd2, 8'd9); idle(10);
    check_rd(2'd3, 8'd0, "R2");
    tag = "R5 R8 R10"; wr(2'd0, 8'h04); idle(300);
    tag = "R11"; check_rd(2'd0, 8'h05, "R11");
    tag = "R13"; wr(2'd0, 8'h0D); check_rd(2'd0, 8'h05, "R13");
    tag = "R12"; wr(2'd0, 8'h05); check_rd(2'd0, 8'h05, "R12");
    wr(2'd0, 8'h04); check_rd(2'd0, 8'h04, "R12");
    tag = "R2"; wr(2'd0, 8'h00); idle(5);
    tag = "R8 R9"; wr(2'd1, 8'd7); wr(2'd2, 8'd7); wr(2'd0, 8'h06);
    idle(4); pulse(); idle(7); pulse(); pulse(); idle(280);
    tag = "R6"; wr(2'd0, 8'h00); wr(2'd0, 8'h08);
    idle(12); pulse(); idle(20); pulse(); idle(3);
    tag = "R6 R9"; wr(2'd0, 8'h00); wr(2'd0, 8'h0A);
    idle(9); pulse(); idle(15); pulse(); idle(5);
    tag = "R7 R11"; wr(2'd0, 8'h00); wr(2'd1, ONES); wr(2'd2, 8'd3);
    wr(2'd0, 8'h0C); idle(600);
    check_rd(2'd0, 8'h0D, "R11");
    tag = "R7 R9"; wr(2'd0, 8'h00); wr(2'd1, 8'd20); wr(2'd0, 8'h0E);
    idle(30); pulse(); idle(40);
    tag = "R3"; wr(2'd0, 8'h00); wr(2'd1, 8'd100); wr(2'd2, 8'd50);
    wr(2'd0, 8'h02); idle(300);
    tag = "R4"; wr(2'd1, 8'd30); idle(150);
    check_rd(2'd1, 8'd30, "R4");
    idle(500);
    tag = "R3 R4"; wr(2'd1, ONES); idle(600);
    finish_run();
  end
endmodule